// File: doc/BRIEF.md
# Set/Clear Register GPIO Port

This block is one 16-bit general-purpose I/O port. Software reaches it over a small register bus. Every control vector has two write locations: one that sets bits and one that clears them. The control vectors are output enable, interrupt enable, trigger kind and trigger sense. Two address windows write the output data one byte at a time. In each window the low address bits act as a per-bit write mask, so a single write changes chosen output bits without a read-modify-write. The block has no shared state, so a chip places one copy per port, and two copies run fully independently.

Input pins pass through a two-flop synchronizer, which is always active. The synchronized value feeds the data-in register and a per-bit trigger detector. Trigger kind and trigger sense together pick one of four modes: low level, falling edge, high level and rising edge. No mode fires on both edges. Each triggered bit sets a pending flag. Software clears a pending flag by writing 1 to it. The pending flags that are enabled are ORed onto one interrupt line.

The request side accepts one access per cycle and is always ready, so it never applies back-pressure. Each read produces exactly one response beat one cycle later. Writes produce no response. The pin side is three plain vectors: input levels, output values and output enables.

Top module: `setclr_gpio_port`

## Requirements
- R1: While reset is held, and right after it ends, the output values, output enables, interrupt enables, trigger kinds, trigger senses, pending flags, the interrupt line and the response valid are all 0.
- R2: Address 0x002 sets output-enable bits (1s in the write data) and 0x003 clears them. A read of either address returns the output-enable vector, and gpio_oe shows it on the next cycle.
- R3: Interrupt enable (set 0x004, clear 0x005), trigger kind (set 0x006, clear 0x007) and trigger sense (set 0x008, clear 0x009) work the same way as output enable.
- R4: A write to 0x100 + m, where m is 8 bits, replaces gpio_out[7:0] with wdata[7:0] only where m has a 1. Bits [15:8] do not change. A read of 0x001 returns gpio_out, and a write to 0x001 changes nothing.
- R5: A write to 0x200 + m replaces gpio_out[15:8] with wdata[15:8] only where m has a 1. Bits [7:0] do not change.
- R6: A read of 0x000 returns the input pins as seen after two synchronizer flops, whatever the output enables are.
- R7: With kind 0 a bit is level-triggered and with kind 1 it is edge-triggered. Sense 0 selects low or falling and sense 1 selects high or rising. An edge compares the synchronized value with its value one cycle earlier. No mode triggers on both edges.
- R8: A level-mode bit sets its pending flag again on every cycle its level holds. If a clear and a trigger arrive in the same cycle, the flag stays set.
- R9: A read of 0x00A returns the pending flags. Writing 1s to 0x00A clears those flags.
- R10: irq is high exactly when some pending flag has its interrupt enable set.
- R11: A read request gives rsp_valid with its data on the next cycle. No other cycle has rsp_valid. req_ready is always 1. Reads of unmapped addresses, including the 0x300 page, return 0.
- R12: A trigger sets a pending flag only while that bit's interrupt enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Always 1, request accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Read data |
| gpio_in | input | 16 | Pin levels |
| gpio_out | output | 16 | Output values |
| gpio_oe | output | 16 | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume at most one access per cycle and that request fields are known whenever req_valid is high. They do not depend on gpio_in, because the pins are treated as fully asynchronous. The stimulus changes pins only between clock edges, drives request fields with defined values on every cycle, and draws addresses from both mapped pages, both byte windows and the unmapped page. Some bits are held at a steady level while their flags are cleared, so level re-triggering is covered.

// File: rtl/setclr_gpio_pkg.sv
package setclr_gpio_pkg;
  localparam int OFS_DIN      = 0;
  localparam int OFS_DOUT     = 1;
  localparam int OFS_OE_SET   = 2;
  localparam int OFS_OE_CLR   = 3;
  localparam int OFS_IE_SET   = 4;
  localparam int OFS_IE_CLR   = 5;
  localparam int OFS_KIND_SET = 6;
  localparam int OFS_KIND_CLR = 7;
  localparam int OFS_SNS_SET  = 8;
  localparam int OFS_SNS_CLR  = 9;
  localparam int OFS_STAT     = 10;

  localparam logic [1:0] PG_REG = 2'b00;
  localparam logic [1:0] PG_LO  = 2'b01;
  localparam logic [1:0] PG_HI  = 2'b10;

  // {sense, kind}
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_FALL = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] lvl_prev_q
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= '0;
      lvl_q      <= '0;
      lvl_prev_q <= '0;
    end else begin
      meta_q     <= pins;
      lvl_q      <= meta_q;
      lvl_prev_q <= lvl_q;
    end
  end
endmodule

// File: rtl/gpio_evt_bit.sv
module gpio_evt_bit
  import setclr_gpio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic lvl_prev,
  input  logic kind,
  input  logic sense,
  input  logic enable,
  input  logic clear,
  output logic pend_q
);
  trig_e mode;
  logic  hit;

  assign mode = trig_e'({sense, kind});

  always_comb begin
    case (mode)
      TRIG_LOW:  hit = ~lvl;
      TRIG_FALL: hit = ~lvl & lvl_prev;
      TRIG_HIGH: hit = lvl;
      TRIG_RISE: hit = lvl & ~lvl_prev;
      default:   hit = 1'b0;
    endcase
  end

  // a fresh trigger outranks a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pend_q <= 1'b0;
    else if (enable && hit)  pend_q <= 1'b1;
    else if (clear)          pend_q <= 1'b0;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import setclr_gpio_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [WIDTH/2+1:0]  req_addr,
  input  logic [WIDTH-1:0]    req_wdata,
  input  logic [WIDTH-1:0]    din,
  input  logic [WIDTH-1:0]    pend,
  output logic [WIDTH-1:0]    dout_q,
  output logic [WIDTH-1:0]    oe_q,
  output logic [WIDTH-1:0]    ie_q,
  output logic [WIDTH-1:0]    kind_q,
  output logic [WIDTH-1:0]    sense_q,
  output logic [WIDTH-1:0]    stat_clr,
  output logic                rsp_valid,
  output logic [WIDTH-1:0]    rsp_rdata
);
  localparam int HALF   = WIDTH / 2;
  localparam int ADDR_W = HALF + 2;

  logic [1:0]      page;
  logic [HALF-1:0] ofs;
  logic            wr, rd;
  logic [WIDTH-1:0] rd_mux;

  assign page = req_addr[ADDR_W-1 -: 2];
  assign ofs  = req_addr[HALF-1:0];
  assign wr   = req_valid & req_write;
  assign rd   = req_valid & ~req_write;

  assign stat_clr = (wr && page == PG_REG && ofs == HALF'(OFS_STAT)) ? req_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      oe_q    <= '0;
      ie_q    <= '0;
      kind_q  <= '0;
      sense_q <= '0;
    end else if (wr) begin
      case (page)
        PG_REG: begin
          if (ofs == HALF'(OFS_OE_SET))   oe_q    <= oe_q | req_wdata;
          if (ofs == HALF'(OFS_OE_CLR))   oe_q    <= oe_q & ~req_wdata;
          if (ofs == HALF'(OFS_IE_SET))   ie_q    <= ie_q | req_wdata;
          if (ofs == HALF'(OFS_IE_CLR))   ie_q    <= ie_q & ~req_wdata;
          if (ofs == HALF'(OFS_KIND_SET)) kind_q  <= kind_q | req_wdata;
          if (ofs == HALF'(OFS_KIND_CLR)) kind_q  <= kind_q & ~req_wdata;
          if (ofs == HALF'(OFS_SNS_SET))  sense_q <= sense_q | req_wdata;
          if (ofs == HALF'(OFS_SNS_CLR))  sense_q <= sense_q & ~req_wdata;
        end
        PG_LO: dout_q[HALF-1:0] <= (dout_q[HALF-1:0] & ~ofs) | (req_wdata[HALF-1:0] & ofs);
        PG_HI: dout_q[WIDTH-1:HALF] <= (dout_q[WIDTH-1:HALF] & ~ofs) |
                                       (req_wdata[WIDTH-1:HALF] & ofs);
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (page == PG_REG) begin
      case (int'(ofs))
        OFS_DIN:                    rd_mux = din;
        OFS_DOUT:                   rd_mux = dout_q;
        OFS_OE_SET, OFS_OE_CLR:     rd_mux = oe_q;
        OFS_IE_SET, OFS_IE_CLR:     rd_mux = ie_q;
        OFS_KIND_SET, OFS_KIND_CLR: rd_mux = kind_q;
        OFS_SNS_SET, OFS_SNS_CLR:   rd_mux = sense_q;
        OFS_STAT:                   rd_mux = pend;
        default:                    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/setclr_gpio_port.sv
module setclr_gpio_port #(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [WIDTH/2+1:0] req_addr,
  input  logic [WIDTH-1:0]   req_wdata,
  output logic               rsp_valid,
  output logic [WIDTH-1:0]   rsp_rdata,
  input  logic [WIDTH-1:0]   gpio_in,
  output logic [WIDTH-1:0]   gpio_out,
  output logic [WIDTH-1:0]   gpio_oe,
  output logic               irq
);
  logic [WIDTH-1:0] lvl, lvl_prev;
  logic [WIDTH-1:0] ie_vec, kind_vec, sense_vec, pend_vec, clr_vec;

  assign req_ready = 1'b1;

  gpio_in_sync #(.WIDTH(WIDTH)) i_sync (
    .clk(clk), .rst_n(rst_n), .pins(gpio_in),
    .lvl_q(lvl), .lvl_prev_q(lvl_prev)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .din(lvl), .pend(pend_vec),
    .dout_q(gpio_out), .oe_q(gpio_oe), .ie_q(ie_vec),
    .kind_q(kind_vec), .sense_q(sense_vec), .stat_clr(clr_vec),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_evt
    gpio_evt_bit i_evt (
      .clk(clk), .rst_n(rst_n),
      .lvl(lvl[b]), .lvl_prev(lvl_prev[b]),
      .kind(kind_vec[b]), .sense(sense_vec[b]),
      .enable(ie_vec[b]), .clear(clr_vec[b]),
      .pend_q(pend_vec[b])
    );
  end

  assign irq = |(pend_vec & ie_vec);
endmodule

// File: rtl/setclr_gpio_port_chk.sv
module setclr_gpio_port_chk #(
  parameter int WIDTH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [WIDTH/2+1:0] req_addr,
  input logic [WIDTH-1:0]   req_wdata,
  input logic               rsp_valid,
  input logic [WIDTH-1:0]   gpio_out,
  input logic [WIDTH-1:0]   gpio_oe,
  input logic               irq,
  input logic [WIDTH-1:0]   ie_vec
);
  localparam int HALF   = WIDTH / 2;
  localparam int ADDR_W = HALF + 2;

  logic wr_pg0, is_rd;
  assign wr_pg0 = req_valid && req_write && req_addr[ADDR_W-1 -: 2] == 2'b00;
  assign is_rd  = req_valid && !req_write;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (gpio_oe == '0 && gpio_out == '0 && !irq && !rsp_valid)); // R1

  AST_OE_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pg0 && req_addr[HALF-1:0] == HALF'(2)) |=>
      ((gpio_oe & $past(req_wdata)) == $past(req_wdata))); // R2

  AST_OE_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pg0 && req_addr[HALF-1:0] == HALF'(3)) |=>
      ((gpio_oe & $past(req_wdata)) == '0)); // R2

  AST_LO_WIN_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[ADDR_W-1 -: 2] == 2'b01) |=>
      $stable(gpio_out[WIDTH-1:HALF])); // R4

  AST_HI_WIN_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[ADDR_W-1 -: 2] == 2'b10) |=>
      $stable(gpio_out[HALF-1:0])); // R5

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rsp_valid); // R11

  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rsp_valid); // R11

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_vec == '0) |-> !irq); // R10
endmodule

bind setclr_gpio_port setclr_gpio_port_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq), .ie_vec(ie_vec)
);

// File: tb/test_setclr_gpio_port.sv
`timescale 1ns/1ps
module test_setclr_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, gpio_in = '0;
  logic        req_ready, rsp_valid, irq;
  logic [15:0] rsp_rdata, gpio_out, gpio_oe;

  int n_checks = 0, n_err = 0;
  bit run = 1'b0;

  always #2 clk = ~clk;

  setclr_gpio_port i_setclr_gpio_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
  );

  // reference model state
  logic [15:0] m_s1, m_s2, m_p, m_dout, m_oe, m_ie, m_kind, m_sns, m_pend, m_rd;
  logic [15:0] ev, clr;
  logic [9:0]  m_raddr;
  logic        m_rv;

  function automatic logic [15:0] trig(input logic [15:0] k, sn, s, p);
    return (k & sn & s & ~p) | (k & ~sn & ~s & p) | (~k & sn & s) | (~k & ~sn & ~s);
  endfunction

  function automatic logic [15:0] exp_read(input logic [9:0] a);
    if (a[9:8] != 2'b00) return '0;
    case (a[7:0])
      8'd0: return m_s2;
      8'd1: return m_dout;
      8'd2, 8'd3: return m_oe;
      8'd4, 8'd5: return m_ie;
      8'd6, 8'd7: return m_kind;
      8'd8, 8'd9: return m_sns;
      8'd10: return m_pend;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [9:0] a);
    if (a[9:8] != 2'b00 || a[7:0] > 8'd10) return "R11 unmapped read";
    case (a[7:0])
      8'd0: return "R6 data-in read";
      8'd1: return "R4 dout read";
      8'd2, 8'd3: return "R2 oe read";
      8'd10: return "R9 status read";
      default: return "R3 control read";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_p <= '0; m_dout <= '0; m_oe <= '0; m_ie <= '0;
      m_kind <= '0; m_sns <= '0; m_pend <= '0; m_rv <= 1'b0; m_rd <= '0; m_raddr <= '0;
    end else begin
      m_s1 <= gpio_in; m_s2 <= m_s1; m_p <= m_s2;
      ev  = trig(m_kind, m_sns, m_s2, m_p) & m_ie;
      clr = (req_valid && req_write && req_addr == 10'd10) ? req_wdata : '0;
      m_pend <= (m_pend & ~clr) | ev;
      m_rv <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        m_rd <= exp_read(req_addr);
        m_raddr <= req_addr;
      end
      if (req_valid && req_write) begin
        case (req_addr[9:8])
          2'b00: case (req_addr[7:0])
            8'd2: m_oe <= m_oe | req_wdata;     8'd3: m_oe <= m_oe & ~req_wdata;
            8'd4: m_ie <= m_ie | req_wdata;     8'd5: m_ie <= m_ie & ~req_wdata;
            8'd6: m_kind <= m_kind | req_wdata; 8'd7: m_kind <= m_kind & ~req_wdata;
            8'd8: m_sns <= m_sns | req_wdata;   8'd9: m_sns <= m_sns & ~req_wdata;
            default: ;
          endcase
          2'b01: m_dout[7:0] <= (m_dout[7:0] & ~req_addr[7:0]) | (req_wdata[7:0] & req_addr[7:0]);
          2'b10: m_dout[15:8] <= (m_dout[15:8] & ~req_addr[7:0]) | (req_wdata[15:8] & req_addr[7:0]);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      chk("R4 R5 gpio_out", gpio_out, m_dout);
      chk("R2 gpio_oe", gpio_oe, m_oe);
      chk("R10 R7 R8 R12 irq", {15'd0, irq}, {15'd0, |(m_pend & m_ie)});
      chk("R11 rsp_valid", {15'd0, rsp_valid}, {15'd0, m_rv});
      chk("R11 req_ready", {15'd0, req_ready}, 16'd1);
      if (m_rv) chk(tag_of(m_raddr), rsp_rdata, m_rd);
    end
  end

  task automatic op(input logic w, input logic [9:0] a, input logic [15:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: outputs during and after reset
    chk("R1 gpio_out in reset", gpio_out, 16'h0);
    chk("R1 gpio_oe in reset", gpio_oe, 16'h0);
    chk("R1 irq in reset", {15'd0, irq}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", {15'd0, rsp_valid}, 16'h0);
    run = 1'b1;
    for (int a = 0; a <= 10; a++) op(1'b0, 10'(a), '0);  // R1 every register reads 0
    // R4 R5 masked byte windows
    op(1'b1, 10'h10F, 16'hFFFF);
    op(1'b1, 10'h280, 16'h80FF);
    op(1'b1, 10'h1F0, 16'hFF50);
    op(1'b1, 10'h001, 16'hFFFF);   // R4 dout location ignores writes
    op(1'b0, 10'h001, '0);
    // R6 input visible while outputs enabled
    op(1'b1, 10'h002, 16'hFFFF);
    gpio_in = 16'hA5C3;
    repeat (3) @(negedge clk);
    op(1'b0, 10'h000, '0);
    // R8: level high on bit 0, clear while level holds
    op(1'b1, 10'h008, 16'h0001);
    op(1'b1, 10'h004, 16'h0001);
    repeat (2) @(negedge clk);
    op(1'b1, 10'h00A, 16'hFFFF);
    op(1'b0, 10'h00A, '0);
    // R7: rising edge on bit 1 must ignore a falling edge
    op(1'b1, 10'h006, 16'h0002);
    op(1'b1, 10'h008, 16'h0002);
    op(1'b1, 10'h004, 16'h0002);
    gpio_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    op(1'b0, 10'h00A, '0);
    gpio_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    op(1'b0, 10'h00A, '0);
    op(1'b1, 10'h00A, 16'h0002);
    op(1'b0, 10'h300, '0);        // R11 unmapped page
    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [9:0] a;
      r = int'($urandom % 16);
      if (r < 11)       a = 10'(r);
      else if (r < 14)  a = {2'b01, 8'($urandom)};
      else if (r == 14) a = {2'b10, 8'($urandom)};
      else              a = {2'b11, 8'($urandom)};
      if ($urandom % 4 == 0) gpio_in = 16'($urandom);
      case ($urandom % 3)
        0: @(negedge clk);
        1: op(1'b0, a, '0);
        default: op(1'b1, a, 16'($urandom));
      endcase
    end
    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule